// File: doc/BRIEF.md
# Addressed Three-Wire Display Frame Receiver

This block takes a slow three-wire serial link made of an enable line, a shift clock and a data line, and turns it into a wide set of registered display outputs: 105 segment bits plus a small control word (four output-port select bits, a bias select, a blanking bit and a standby bit). All three wires are sampled in a faster system clock domain. The enable line and the shift clock are synchronised, and their edges are found in that domain.

A transfer has two phases. While the enable line is low, an 8-bit device address is shifted in on rising shift-clock edges, least significant bit first. When the enable line rises, the last eight bits received are compared with the device address. If they match, a 48-bit frame is shifted in while the enable line is high. The last two bits of the frame are a group select. When the enable line falls, a frame of exactly 48 bits is copied into the latch group it selects. Any other transfer is dropped, so a host can refresh one third of the segments without touching the others.

Top module: `disp_frame_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, every segment output and every control output is 0.
- R2: The address is taken least significant bit first from rising shift-clock edges with the enable line low. Only the last 8 bits before the enable line rises are compared, and they must equal 0x46. For example, 0x62 (the same pattern sent most significant bit first) does not match.
- R3: Group select 00 (frame bit 46 = 0, frame bit 47 = 0, with frame bit k being the k-th bit received, counting from 0) copies frame bits 0..35 to seg_o[35:0], with frame bit k going to seg_o[k].
- R4: A group-00 frame also loads port_sel_o[j] from frame bit 39+j (j = 0..3), half_bias_o from bit 43, blank_o from bit 44 and standby_o from bit 45. Bits 36..38 are ignored.
- R5: Group select 01 (bit 46 = 0, bit 47 = 1) copies frame bits 0..35 to seg_o[71:36].
- R6: Group select 10 (bit 46 = 1, bit 47 = 0) copies frame bits 0..32 to seg_o[104:72]. Filler bits 33..45 have no effect on any output.
- R7: Group select 11 changes no output.
- R8: A frame of any length other than 48 bits, for example 47 or 49 bits, changes no output.
- R9: If the address does not match, the following frame changes no output, even when it is exactly 48 bits long.
- R10: Outputs hold their values while the address and frame bits are shifting. They can change only after the enable line falls.
- R11: A frame for one group leaves the segment bits of the other two groups and the control outputs unchanged, except for the control fields that a group-00 frame loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial wires are oversampled in this domain |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Enable line: low for the address phase, high for the frame phase |
| cl_in | input | 1 | Shift clock; bits are taken on its rising edge |
| di_in | input | 1 | Serial data line |
| seg_o | output | 105 | Latched segment bits, seg_o[n] being display bit n+1 |
| port_sel_o | output | 4 | Output-port select field |
| half_bias_o | output | 1 | Bias select: 1 for half bias, 0 for third bias |
| blank_o | output | 1 | Segment blanking: 1 forces segments off |
| standby_o | output | 1 | Power-saving mode request |

## Verification
The two functions that meet in one cycle are the end-of-frame decision and the address bookkeeping. On the system clock edge that sees the enable line fall, the latch write must use the match flag and the bit count as they stood before that same edge clears both. The bench provokes this on every transfer and mixes in frames with a bad address, a wrong length or group 11 placed right after good ones. A stale match or count would then corrupt the outputs. Every output is compared with a bench model once the enable line has fallen, and again just before it falls, to confirm the outputs held while the frame was shifting.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    GRP_LOW  = 2'b00,
    GRP_MID  = 2'b01,
    GRP_HIGH = 2'b10,
    GRP_NONE = 2'b11
  } grp_t;

  typedef struct packed {
    logic [3:0] port_sel;
    logic       half_bias;
    logic       blank;
    logic       standby;
  } ctrl_t;
endpackage

// File: rtl/dfr_sync.sv
module dfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dfr_addr_match.sv
module dfr_addr_match #(
  parameter int          AW   = 8,
  parameter logic [AW-1:0] ADDR = 8'h46
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_lvl,
  input  logic ce_rise,
  input  logic ce_fall,
  input  logic cl_rise,
  input  logic di,
  output logic addr_ok
);
  logic [AW-1:0] sr_q;

  // least significant bit arrives first, so shift toward bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (cl_rise && !ce_lvl) begin
      sr_q <= {di, sr_q[AW-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          addr_ok <= 1'b0;
    else if (ce_rise) addr_ok <= (sr_q == ADDR);
    else if (ce_fall) addr_ok <= 1'b0;
  end

  // R2: the match flag can only come up on the enable rising edge
  a_r2_match_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!addr_ok && !ce_rise) |=> !addr_ok);
endmodule

// File: rtl/dfr_frame_shift.sv
module dfr_frame_shift #(
  parameter int FW = 48,
  localparam int CW = $clog2(FW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_lvl,
  input  logic          ce_fall,
  input  logic          cl_rise,
  input  logic          di,
  input  logic          addr_ok,
  output logic [FW-1:0] frame_o,
  output logic          full_o
);
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [CW-1:0] OVER = CW'(FW + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      frame_o <= '0;
    end else if (ce_fall) begin
      cnt_q <= '0;
    end else if (ce_lvl && addr_ok && cl_rise) begin
      if (cnt_q < FULL) begin
        frame_o[cnt_q] <= di;
        cnt_q          <= cnt_q + 1'b1;
      end else begin
        cnt_q <= OVER;
      end
    end
  end

  assign full_o = (cnt_q == FULL);

  // R9: without an address match no frame bit is ever counted
  a_r9_idle_count: assert property (@(posedge clk) disable iff (rst)
    !addr_ok |-> (cnt_q == '0));
  // R8: the counter never runs past the overlength marker
  a_r8_count_cap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == OVER) |=> (cnt_q == OVER) || (cnt_q == '0));
endmodule

// File: rtl/dfr_latch_bank.sv
module dfr_latch_bank
  import dfr_pkg::*;
#(
  parameter int FW       = 48,
  parameter int G0_LEN   = 36,
  parameter int G1_LEN   = 36,
  parameter int G2_LEN   = 33,
  parameter int CTRL_POS = 39,
  localparam int SEG_W   = G0_LEN + G1_LEN + G2_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [FW-1:0]    frame,
  output logic [SEG_W-1:0] seg_o,
  output ctrl_t            ctrl_o
);
  grp_t dir;
  assign dir = grp_t'({frame[FW-2], frame[FW-1]});

  for (genvar g = 0; g < 3; g++) begin : g_grp
    localparam int LEN = (g == 0) ? G0_LEN : (g == 1) ? G1_LEN : G2_LEN;
    localparam int OFF = (g == 0) ? 0 : (g == 1) ? G0_LEN : G0_LEN + G1_LEN;
    logic [LEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (load && (dir == grp_t'(g))) q <= frame[LEN-1:0];
    end
    assign seg_o[OFF +: LEN] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
    end else if (load && dir == GRP_LOW) begin
      ctrl_o.port_sel  <= frame[CTRL_POS +: 4];
      ctrl_o.half_bias <= frame[CTRL_POS + 4];
      ctrl_o.blank     <= frame[CTRL_POS + 5];
      ctrl_o.standby   <= frame[CTRL_POS + 6];
    end
  end

  // R10: nothing moves without a load strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(seg_o) && $stable(ctrl_o)));
  // R7: group 11 is discarded
  a_r7_void_dir: assert property (@(posedge clk) disable iff (rst)
    (load && dir == GRP_NONE) |=> ($stable(seg_o) && $stable(ctrl_o)));
  // R3: low group copies the head of the frame
  a_r3_low_copy: assert property (@(posedge clk) disable iff (rst)
    (load && dir == GRP_LOW) |=> (seg_o[G0_LEN-1:0] == $past(frame[G0_LEN-1:0])));
  // R11: a middle-group frame leaves the other groups and control alone
  a_r11_other_groups: assert property (@(posedge clk) disable iff (rst)
    (load && dir == GRP_MID) |=> ($stable(seg_o[G0_LEN-1:0]) &&
      $stable(seg_o[SEG_W-1:G0_LEN+G1_LEN]) && $stable(ctrl_o)));
endmodule

// File: rtl/disp_frame_rx.sv
module disp_frame_rx
  import dfr_pkg::*;
#(
  parameter int          FW       = 48,
  parameter int          AW       = 8,
  parameter logic [AW-1:0] ADDR   = 8'h46,
  parameter int          SYNC_N   = 2,
  parameter int          G0_LEN   = 36,
  parameter int          G1_LEN   = 36,
  parameter int          G2_LEN   = 33,
  parameter int          CTRL_POS = 39,
  localparam int         SEG_W    = G0_LEN + G1_LEN + G2_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_in,
  input  logic             cl_in,
  input  logic             di_in,
  output logic [SEG_W-1:0] seg_o,
  output logic [3:0]       port_sel_o,
  output logic             half_bias_o,
  output logic             blank_o,
  output logic             standby_o
);
  logic [2:0] wires_s;
  logic ce_s, cl_s, di_s, ce_q, cl_q;
  logic ce_rise, ce_fall, cl_rise;
  logic addr_ok, full;
  logic [FW-1:0] frame;
  ctrl_t ctrl;

  dfr_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .async_i({ce_in, cl_in, di_in}), .sync_o(wires_s));

  assign {ce_s, cl_s, di_s} = wires_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b0;
      cl_q <= 1'b0;
    end else begin
      ce_q <= ce_s;
      cl_q <= cl_s;
    end
  end

  assign ce_rise = ce_s & ~ce_q;
  assign ce_fall = ~ce_s & ce_q;
  assign cl_rise = cl_s & ~cl_q;

  dfr_addr_match #(.AW(AW), .ADDR(ADDR)) u_addr (
    .clk(clk), .rst(rst), .ce_lvl(ce_s), .ce_rise(ce_rise), .ce_fall(ce_fall),
    .cl_rise(cl_rise), .di(di_s), .addr_ok(addr_ok));

  dfr_frame_shift #(.FW(FW)) u_shift (
    .clk(clk), .rst(rst), .ce_lvl(ce_s), .ce_fall(ce_fall), .cl_rise(cl_rise),
    .di(di_s), .addr_ok(addr_ok), .frame_o(frame), .full_o(full));

  dfr_latch_bank #(.FW(FW), .G0_LEN(G0_LEN), .G1_LEN(G1_LEN), .G2_LEN(G2_LEN),
                   .CTRL_POS(CTRL_POS)) u_bank (
    .clk(clk), .rst(rst), .load(ce_fall & addr_ok & full), .frame(frame),
    .seg_o(seg_o), .ctrl_o(ctrl));

  assign port_sel_o  = ctrl.port_sel;
  assign half_bias_o = ctrl.half_bias;
  assign blank_o     = ctrl.blank;
  assign standby_o   = ctrl.standby;
endmodule

// File: tb/tb_disp_frame_rx.sv
module tb_disp_frame_rx;
  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic [104:0] seg;
  logic [3:0] ps;
  logic hb, bl, sb;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [104:0] m_seg = '0;
  logic [6:0]   m_ctl = '0;   // {ps, hb, bl, sb}

  always #2 clk = ~clk;

  disp_frame_rx dut (.clk(clk), .rst(rst), .ce_in(ce), .cl_in(cl), .di_in(di),
    .seg_o(seg), .port_sel_o(ps), .half_bias_o(hb), .blank_o(bl), .standby_o(sb));

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    checks++;
    if (seg !== m_seg) begin
      fails++;
      $display("FAIL %s seg actual=%h expected=%h", req, seg, m_seg);
    end
    checks++;
    if ({ps, hb, bl, sb} !== m_ctl) begin
      fails++;
      $display("FAIL %s ctrl actual=%b expected=%b", req, {ps, hb, bl, sb}, m_ctl);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk) di = b;
    wait_clk(4);
    @(negedge clk) cl = 1'b1;
    wait_clk(4);
    @(negedge clk) cl = 1'b0;
  endtask

  task automatic send_addr(logic [7:0] a, int pre);
    for (int i = 0; i < pre; i++) send_bit(1'($urandom));
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    wait_clk(4);
    @(negedge clk) ce = 1'b1;
    wait_clk(6);
  endtask

  // shifts n bits, checks R10 hold before releasing the enable line
  task automatic send_frame(logic [49:0] f, int n, string req);
    for (int i = 0; i < n; i++) send_bit(f[i]);
    wait_clk(4);
    check_all("R10");
    @(negedge clk) ce = 1'b0;
    wait_clk(10);
  endtask

  function automatic logic [49:0] build(int g, logic [35:0] d, logic [6:0] c, logic [12:0] fill);
    logic [49:0] f = '0;
    f[35:0] = d;
    if (g == 0) begin
      f[39] = c[6]; f[40] = c[5]; f[41] = c[4]; f[42] = c[3];
      f[43] = c[2]; f[44] = c[1]; f[45] = c[0];
    end else if (g == 1) begin
      f[45:36] = fill[9:0];
    end else begin
      f[45:33] = fill;
    end
    f[46] = g[1];
    f[47] = g[0];
    f[49:48] = 2'($urandom);
    return f;
  endfunction

  // c is {ps[3:0], hb, bl, sb} with ps bit j from frame bit 39+j
  function automatic logic [6:0] ctl_pack(logic [3:0] p, logic h, logic b, logic s);
    return {p, h, b, s};
  endfunction

  task automatic model(int g, logic [35:0] d, logic [3:0] p, logic h, logic b, logic s);
    if (g == 0) begin
      m_seg[35:0] = d;
      m_ctl = ctl_pack(p, h, b, s);
    end else if (g == 1) m_seg[71:36] = d;
    else if (g == 2) m_seg[104:72] = d[32:0];
  endtask

  task automatic xfer(logic [7:0] a, int g, logic [35:0] d, logic [3:0] p,
                      logic h, logic b, logic s, int n, string req);
    logic [49:0] f;
    logic [12:0] fill = 13'($urandom);
    if (g == 2) d[35:33] = 3'($urandom);
    // frame bit 39+j carries p[j]; ctl arg order {p[0],p[1],p[2],p[3],...} into f[39..42]
    f = build(g, d, {p[0], p[1], p[2], p[3], h, b, s}, fill);
    send_addr(a, 0);
    send_frame(f, n, req);
    if (a == 8'h46 && n == 48 && g != 3) model(g, d, p, h, b, s);
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd2024));
    wait_clk(5);
    @(negedge clk);
    checks++;
    if (seg !== '0 || {ps, hb, bl, sb} !== '0) begin
      fails++; $display("FAIL R1 during reset actual=%h expected=0", seg);
    end
    @(negedge clk) rst = 1'b0;
    check_all("R1");

    // directed cases
    xfer(8'h46, 0, {18{2'b10}}, 4'b1010, 1, 0, 1, 48, "R3 R4");
    xfer(8'h46, 1, 36'hF_0F0F_0F0F, 4'b0, 0, 0, 0, 48, "R5 R11");
    xfer(8'h46, 2, 36'h1_2345_6789, 4'b0, 0, 0, 0, 48, "R6 R11");
    xfer(8'h46, 0, 36'h0_0000_0001, 4'b0101, 0, 1, 0, 48, "R3 R4");
    xfer(8'h46, 3, 36'hF_FFFF_FFFF, 4'b1111, 1, 1, 1, 48, "R7");
    xfer(8'h46, 0, 36'hA_AAAA_AAAA, 4'b1111, 1, 1, 1, 47, "R8 short");
    xfer(8'h46, 1, 36'h5_5555_5555, 4'b1111, 1, 1, 1, 49, "R8 long");
    xfer(8'h62, 0, 36'hF_FFFF_FFFF, 4'b1111, 1, 1, 1, 48, "R2 bit order");
    xfer(8'h47, 2, 36'hF_FFFF_FFFF, 4'b1111, 1, 1, 1, 48, "R9");
    begin : pre_bits
      logic [49:0] f = build(1, 36'h3_C3C3_C3C3, 7'b0, 13'h1FFF);
      send_addr(8'h46, 5);
      send_frame(f, 48, "R2");
      m_seg[71:36] = 36'h3_C3C3_C3C3;
      check_all("R2 trailing eight bits");
    end

    // constrained random
    for (int t = 0; t < 36; t++) begin
      int kind = int'($urandom_range(0, 9));
      int g = int'($urandom_range(0, 3));
      logic [7:0] a = (kind == 0) ? 8'($urandom) | 8'h01 : 8'h46;
      int n = (kind == 1) ? ((($urandom & 1) != 0) ? 47 : 49) : 48;
      if (a == 8'h46 && kind == 0) a = 8'h47;
      xfer(a, g, 36'($urandom) ^ {4'($urandom), 32'd0} ^ {32'($urandom), 4'd0},
           4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), n,
           (g == 3) ? "R7" : (a != 8'h46) ? "R9" : (n != 48) ? "R8" :
           (g == 0) ? "R3 R4" : (g == 1) ? "R5 R11" : "R6 R11");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule